// File: doc/BRIEF.md
# Hashed Inverted Page Table Walker

This block translates a virtual page number into a physical page number by searching an inverted page table. The table has one entry per physical page, so the position of the matching entry is the physical page number. No separate frame field is stored. The walker folds the virtual page number into a table index with an XOR hash. It then reads entries through a read port with variable latency. It compares each entry's stored tag against the requested number, and on a mismatch it follows the entry's link to the next entry that shares the same hash.

A client offers a page number with a valid/ready handshake. The walker accepts one request at a time. When the search ends, it pulses a response carrying a hit/fault flag, the physical page number and the count of entries it read. The same software that fills the table also handles faults; neither task belongs to this block.

Top module: `ipt_walker`

## Requirements
- R1: After reset, `req_ready` is 1 and both `resp_valid` and `rd_req` are 0.
- R2: The first entry read for a request is at index `vpn[9:0] XOR {1'b0, vpn[18:10]}`.
- R3: Entry layout: bit 31 = entry valid, bits [30:12] = 19-bit tag, bit 11 = link valid, bits [9:0] = link index. An entry whose valid bit is set and whose tag equals the request ends the search with `resp_hit`=1 and `resp_ppn` equal to that entry's index.
- R4: When an entry does not match and its link-valid bit is set, the next read goes to the entry's link index.
- R5: When an entry does not match and its link-valid bit is clear, the search ends with `resp_hit`=0.
- R6: An entry with bit 31 clear never produces a hit, even if its tag field equals the request. The search continues through its link if one is present.
- R7: `resp_probes` equals the number of table entries read for that request.
- R8: A request reads at most 16 entries. After the 16th read, a mismatch ends the search with a fault and `resp_probes`=16. A match on the 16th read is still a hit.
- R9: `rd_req` is a single-cycle pulse. It is issued again only after `rd_valid` has returned the data of the previous read.
- R10: Results do not depend on read latency. From acceptance until the response, `req_ready` is 0, and any `req_valid` offered in that time is ignored. `resp_valid` lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Walker idle, request accepted on this cycle if valid |
| req_vpn | input | 19 | Virtual page number to translate |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_hit | output | 1 | 1 = translation found, 0 = page fault |
| resp_ppn | output | 10 | Physical page number (index of matching entry) |
| resp_probes | output | 5 | Number of entries read |
| rd_req | output | 1 | Table read request pulse |
| rd_addr | output | 10 | Table index to read |
| rd_valid | input | 1 | Read data returned |
| rd_data | input | 32 | Table entry |

## Verification
Every cycle, the assertions check the following: the first read lands on the hashed index, each step after a link goes to the linked index, a tag match turns into a hit response naming the entry just read, the probe counter never passes its cap, and read and response strobes stay single-cycle. The bench scenarios show the rest. These are chain depths of one to sixteen, collisions that end in a fault, a valid-clear entry whose tag matches, a cyclic chain cut off at the limit, and identical results under two read-latency profiles. They also show that a request offered while the walker is busy leaves no trace.

// File: rtl/ipt_pkg.sv
package ipt_pkg;
  typedef enum logic [1:0] {
    WK_IDLE  = 2'd0,
    WK_ISSUE = 2'd1,
    WK_WAIT  = 2'd2,
    WK_RESP  = 2'd3
  } walk_state_e;
endpackage

// File: rtl/ipt_hash.sv
module ipt_hash #(
  parameter int VPN_W = 19,
  parameter int IDX_W = 10
) (
  input  logic [VPN_W-1:0] vpn,
  output logic [IDX_W-1:0] idx
);
  localparam int NCHUNK = (VPN_W + IDX_W - 1) / IDX_W;
  localparam int PAD_W  = NCHUNK * IDX_W;

  logic [PAD_W-1:0] padded;
  assign padded = PAD_W'(vpn);

  // XOR-fold the zero-extended page number in IDX_W-wide slices
  always_comb begin
    idx = '0;
    for (int c = 0; c < NCHUNK; c++) begin
      idx = idx ^ padded[c*IDX_W +: IDX_W];
    end
  end
endmodule

// File: rtl/ipt_entry_cmp.sv
module ipt_entry_cmp #(
  parameter int VPN_W   = 19,
  parameter int IDX_W   = 10,
  parameter int ENTRY_W = 32
) (
  input  logic [ENTRY_W-1:0] entry,
  input  logic [VPN_W-1:0]   vpn,
  output logic               tag_hit,
  output logic               chain_next,
  output logic [IDX_W-1:0]   link_idx
);
  localparam int VALID_B = ENTRY_W - 1;
  localparam int TAG_LSB = ENTRY_W - 1 - VPN_W;
  localparam int LINKV_B = IDX_W + 1;

  logic             ent_valid;
  logic [VPN_W-1:0] ent_tag;

  assign ent_valid  = entry[VALID_B];
  assign ent_tag    = entry[TAG_LSB +: VPN_W];
  assign tag_hit    = ent_valid && (ent_tag == vpn);
  assign chain_next = !tag_hit && entry[LINKV_B];
  assign link_idx   = entry[IDX_W-1:0];
endmodule

// File: rtl/ipt_walk_ctrl.sv
module ipt_walk_ctrl
  import ipt_pkg::*;
#(
  parameter int VPN_W      = 19,
  parameter int IDX_W      = 10,
  parameter int MAX_PROBES = 16,
  parameter int CNT_W      = $clog2(MAX_PROBES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [VPN_W-1:0] req_vpn,
  input  logic [IDX_W-1:0] start_idx,
  output logic             req_ready,
  output logic             rd_req,
  output logic [IDX_W-1:0] rd_addr,
  input  logic             rd_valid,
  input  logic             tag_hit,
  input  logic             chain_next,
  input  logic [IDX_W-1:0] link_idx,
  output logic [VPN_W-1:0] cur_vpn,
  output logic             resp_valid,
  output logic             resp_hit,
  output logic [IDX_W-1:0] resp_ppn,
  output logic [CNT_W-1:0] resp_probes
);
  walk_state_e      state;
  logic [IDX_W-1:0] cur_idx;
  logic [VPN_W-1:0] vpn_q;
  logic [CNT_W-1:0] probes;
  logic             hit_q;

  // named events for checking
  logic accept, rd_done, found, step, stop;
  assign accept  = req_valid && (state == WK_IDLE);
  assign rd_done = rd_valid && (state == WK_WAIT);
  assign found   = rd_done && tag_hit;
  assign step    = rd_done && chain_next && (probes < CNT_W'(MAX_PROBES));
  assign stop    = rd_done && !found && !step;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= WK_IDLE;
      cur_idx <= '0;
      vpn_q   <= '0;
      probes  <= '0;
      hit_q   <= 1'b0;
    end else begin
      case (state)
        WK_IDLE: if (accept) begin
          vpn_q   <= req_vpn;
          cur_idx <= start_idx;
          probes  <= '0;
          hit_q   <= 1'b0;
          state   <= WK_ISSUE;
        end
        WK_ISSUE: begin
          probes <= probes + 1'b1;
          state  <= WK_WAIT;
        end
        WK_WAIT: begin
          if (found) begin
            hit_q <= 1'b1;
            state <= WK_RESP;
          end else if (step) begin
            cur_idx <= link_idx;
            state   <= WK_ISSUE;
          end else if (stop) begin
            hit_q <= 1'b0;
            state <= WK_RESP;
          end
        end
        default: state <= WK_IDLE;
      endcase
    end
  end

  assign req_ready   = (state == WK_IDLE);
  assign rd_req      = (state == WK_ISSUE);
  assign rd_addr     = cur_idx;
  assign cur_vpn     = vpn_q;
  assign resp_valid  = (state == WK_RESP);
  assign resp_hit    = hit_q;
  assign resp_ppn    = cur_idx;
  assign resp_probes = probes;

  AST_READ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> !rd_req); // R9
  AST_PROBE_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    probes <= CNT_W'(MAX_PROBES)); // R8
  AST_LINK_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> rd_req && (rd_addr == $past(link_idx))); // R4
  AST_HIT_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    found |=> resp_valid && resp_hit && (resp_ppn == $past(rd_addr))); // R3
  AST_RESP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> !resp_valid && req_ready); // R10
endmodule

// File: rtl/ipt_walker.sv
module ipt_walker #(
  parameter int VPN_W      = 19,
  parameter int IDX_W      = 10,
  parameter int ENTRY_W    = 32,
  parameter int MAX_PROBES = 16,
  localparam int CNT_W     = $clog2(MAX_PROBES + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [VPN_W-1:0]   req_vpn,
  output logic               resp_valid,
  output logic               resp_hit,
  output logic [IDX_W-1:0]   resp_ppn,
  output logic [CNT_W-1:0]   resp_probes,
  output logic               rd_req,
  output logic [IDX_W-1:0]   rd_addr,
  input  logic               rd_valid,
  input  logic [ENTRY_W-1:0] rd_data
);
  logic [IDX_W-1:0] start_idx;
  logic [IDX_W-1:0] link_idx;
  logic [VPN_W-1:0] cur_vpn;
  logic             tag_hit;
  logic             chain_next;

  ipt_hash #(.VPN_W(VPN_W), .IDX_W(IDX_W)) u_hash (
    .vpn (req_vpn),
    .idx (start_idx)
  );

  ipt_entry_cmp #(.VPN_W(VPN_W), .IDX_W(IDX_W), .ENTRY_W(ENTRY_W)) u_cmp (
    .entry      (rd_data),
    .vpn        (cur_vpn),
    .tag_hit    (tag_hit),
    .chain_next (chain_next),
    .link_idx   (link_idx)
  );

  ipt_walk_ctrl #(
    .VPN_W(VPN_W), .IDX_W(IDX_W), .MAX_PROBES(MAX_PROBES), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_vpn     (req_vpn),
    .start_idx   (start_idx),
    .req_ready   (req_ready),
    .rd_req      (rd_req),
    .rd_addr     (rd_addr),
    .rd_valid    (rd_valid),
    .tag_hit     (tag_hit),
    .chain_next  (chain_next),
    .link_idx    (link_idx),
    .cur_vpn     (cur_vpn),
    .resp_valid  (resp_valid),
    .resp_hit    (resp_hit),
    .resp_ppn    (resp_ppn),
    .resp_probes (resp_probes)
  );

  AST_FIRST_PROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rd_req && (rd_addr == $past(start_idx))); // R2
  AST_BUSY_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> !req_ready && !resp_valid); // R10
endmodule

// File: tb/ipt_walker_tb.sv
`timescale 1ns/1ps
module ipt_walker_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [18:0] req_vpn = '0;
  logic        resp_valid, resp_hit;
  logic [9:0]  resp_ppn;
  logic [4:0]  resp_probes;
  logic        rd_req;
  logic [9:0]  rd_addr;
  logic        rd_valid = 1'b0;
  logic [31:0] rd_data = '0;

  always #4 clk = ~clk;

  ipt_walker u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_vpn(req_vpn), .resp_valid(resp_valid), .resp_hit(resp_hit),
    .resp_ppn(resp_ppn), .resp_probes(resp_probes), .rd_req(rd_req),
    .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  int checks = 0;
  int failures = 0;
  bit done = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ent(input bit v, input logic [18:0] tag,
                                      input bit lv, input logic [9:0] link);
    return {v, tag, lv, 1'b0, link};
  endfunction

  function automatic logic [9:0] fold(input logic [18:0] v);
    return v[9:0] ^ {1'b0, v[18:10]};
  endfunction

  // table memory model with variable latency
  logic [31:0] mem [1024];
  int lat_extra = 0;
  int rd_count = 0;
  logic [9:0] first_addr = '0;
  int pend = 0;
  logic [9:0] pend_addr = '0;

  initial begin
    forever begin
      @(negedge clk);
      rd_valid = 1'b0;
      if (pend > 0) begin
        pend--;
        if (pend == 0) begin
          rd_valid = 1'b1;
          rd_data  = mem[pend_addr];
        end
      end else if (rd_req) begin
        if (rd_count == 0) first_addr = rd_addr;
        rd_count++;
        pend_addr = rd_addr;
        pend = 1 + int'(rd_addr[1:0]) + lat_extra;
      end
    end
  end

  // {vpn, hit, ppn, probes}
  localparam int NV = 11;
  localparam logic [34:0] VEC [NV] = '{
    {19'h00123, 1'b1, 10'h123, 5'd1},   // R3 direct hit
    {19'h00055, 1'b1, 10'h055, 5'd1},   // R3 chain head
    {19'h00454, 1'b1, 10'h200, 5'd2},   // R4 second in chain
    {19'h00857, 1'b1, 10'h300, 5'd3},   // R4 third in chain
    {19'h00C56, 1'b0, 10'h000, 5'd3},   // R5 chain exhausted
    {19'h00077, 1'b1, 10'h078, 5'd2},   // R6 invalid entry skipped
    {19'h00010, 1'b0, 10'h000, 5'd1},   // R5 empty slot
    {19'h00400, 1'b0, 10'h000, 5'd16},  // R8 cyclic chain
    {19'h7FFFF, 1'b0, 10'h000, 5'd2},   // R5 high bits fold
    {19'h40000, 1'b1, 10'h100, 5'd1},   // R2 top bit in hash
    {19'h003A0, 1'b1, 10'h3AF, 5'd16}   // R8 hit on last allowed probe
  };

  task automatic do_req(input logic [18:0] v, output bit got);
    got = 0;
    @(negedge clk);
    rd_count = 0;
    req_vpn = v;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    for (int c = 0; c < 3000; c++) begin
      if (resp_valid) begin got = 1; break; end
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    bit got;
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    mem[10'h123] = ent(1, 19'h00123, 0, 0);
    mem[10'h055] = ent(1, 19'h00055, 1, 10'h200);
    mem[10'h200] = ent(1, 19'h00454, 1, 10'h300);
    mem[10'h300] = ent(1, 19'h00857, 0, 0);
    mem[10'h077] = ent(0, 19'h00077, 1, 10'h078);
    mem[10'h078] = ent(1, 19'h00077, 0, 0);
    mem[10'h001] = ent(1, 19'h7FFFF, 1, 10'h002);
    mem[10'h002] = ent(1, 19'h7FFFE, 1, 10'h001);
    mem[10'h100] = ent(1, 19'h40000, 0, 0);
    for (int i = 0; i < 15; i++) mem[10'h3A0 + i] = ent(1, 19'h0, 1, 10'(10'h3A1 + i));
    mem[10'h3AF] = ent(1, 19'h003A0, 0, 0);

    repeat (3) @(negedge clk);
    check(req_ready == 1'b1, "R1 ready", req_ready, 1);
    check(resp_valid == 1'b0, "R1 resp_valid", resp_valid, 0);
    check(rd_req == 1'b0, "R1 rd_req", rd_req, 0);
    rst_n = 1'b1;

    for (int pass = 0; pass < 2; pass++) begin
      lat_extra = pass * 3;  // R10 latency independence
      for (int k = 0; k < NV; k++) begin
        logic [18:0] v; bit eh; logic [9:0] ep; logic [4:0] en;
        {v, eh, ep, en} = VEC[k];
        do_req(v, got);
        check(got, "R10 response arrives", got, 1);
        check(resp_hit == eh, "R3/R5 hit flag", resp_hit, eh);
        if (eh) check(resp_ppn == ep, "R3 ppn", resp_ppn, ep);
        check(resp_probes == en, "R7 probes", resp_probes, en);
        check(rd_count == int'(en), "R9 reads issued", rd_count, en);
        check(rd_count <= 16, "R8 read cap", rd_count, 16);
        check(first_addr == fold(v), "R2 first index", first_addr, fold(v));
      end
    end

    // R10: request offered while busy is ignored
    lat_extra = 2;
    @(negedge clk);
    rd_count = 0;
    req_vpn = 19'h00857; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (2) @(negedge clk);
    check(req_ready == 1'b0, "R10 busy ready low", req_ready, 0);
    req_vpn = 19'h00123; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    got = 0;
    for (int c = 0; c < 200; c++) begin
      if (resp_valid) begin got = 1; break; end
      @(negedge clk);
    end
    check(got && resp_hit && resp_ppn == 10'h300, "R10 first result kept", resp_ppn, 10'h300);
    check(rd_count == 3, "R10 read count", rd_count, 3);
    @(negedge clk);
    check(resp_valid == 1'b0, "R10 resp one cycle", resp_valid, 0);
    begin
      int extra = 0;
      for (int c = 0; c < 8; c++) begin
        if (rd_req || resp_valid) extra++;
        @(negedge clk);
      end
      check(extra == 0, "R10 busy request dropped", extra, 0);
    end
    check(rd_count == 3, "R9 no stray reads", rd_count, 3);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule